// File: doc/BRIEF.md
# Link Synchronization Mode Controller

This block steps a serial link transmitter through its three operating modes, one decision per reference-clock word. After reset, or after the power-down input is released, it waits out a fixed lock interval with every output quiet. Once locked it either sends payload words or, when the far end asks for resynchronization, sends sync words. The block itself drives only the mode flags. The word datapath and the serial shifter read those flags.

A resync request is the OR of two request pins. The combined request must stay high for six consecutive words before it counts. Once it counts, a burst of 1024 sync words follows that nothing but reset or power-down can cut short. The burst stretches for as long as the request stays high. Payload resumes on the first word after the request is seen low at or after the end of the burst.

Top module: `linksync_ctrl`

## Requirements
- R1: Either request input alone, or both together, has the same effect; the block acts on their logical OR.
- R2: A burst starts only after the combined request was high at six consecutive clock edges; `send_sync` rises on the word after the sixth such edge. A single low edge restarts the count, so 3 high, 1 low, 3 high starts nothing.
- R3: A started burst lasts at least 1024 words, and exactly 1024 words if the request is low at its last word, whatever the request does during the burst.
- R4: If the request is still high at the last burst word, sync words continue until the first edge that samples it low. A request held high for H edges (H ≥ 6) gives max(1024, H−5) sync words. The next word is a data word.
- R5: A qualified request while in data mode ends data mode and starts a new burst.
- R6: While `rst` is high, and for 2047 edges after it falls, `locked`, `send_sync` and `data_valid` are 0. `locked` is 1 after the 2048th edge.
- R7: `pwr_down_n` low clears all three outputs from the next edge on. After release, the full 2048-edge lock wait is repeated.
- R8: `data_valid` is 1 only when locked, not in sync mode, and with the combined request sampled low at the same edge. A request that is high but not yet qualified therefore produces idle words, not data.
- R9: A request that has qualified before lock completes sends the block straight from the lock wait into a burst, with no data word in between.
- R10: Every word is exactly one of idle, sync or data: `send_sync` and `data_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference word clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_down_n | input | 1 | Power-down, active low; low restarts the lock wait |
| req_a | input | 1 | Resync request, first source |
| req_b | input | 1 | Resync request, second source |
| send_sync | output | 1 | Current word is a sync word |
| locked | output | 1 | Lock wait finished |
| data_valid | output | 1 | Current word carries payload |

## Verification
Two pairs of events can fall on the same edge. Lock expiry can coincide with a request that has already qualified. The last word of a burst can coincide with the request's own falling edge or its continued presence. The first pair is provoked by holding a request high through reset release and the lock wait. The check is that `send_sync`, not `data_valid`, turns on at the 2048th edge. The second pair is provoked by request pulses of exactly six edges and of 1500 edges. The measured sync-word counts are compared against max(1024, H−5), and a data word must immediately follow.

// File: rtl/linksync_pkg.sv
package linksync_pkg;

    typedef enum logic [1:0] {
        MODE_INIT = 2'd0,
        MODE_SYNC = 2'd1,
        MODE_DATA = 2'd2
    } link_mode_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/linksync_qualify.sv
module linksync_qualify #(
    parameter int unsigned QUAL_LEN = 6
) (
    input  logic clk,
    input  logic clr,
    input  logic req,
    output logic qualified
);
    localparam int unsigned QW = linksync_pkg::cnt_width(QUAL_LEN);
    localparam logic [QW-1:0] QTOP = QW'(QUAL_LEN - 1);

    logic [QW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (clr || !req)
            run_q <= '0;
        else if (run_q != QTOP)
            run_q <= run_q + 1'b1;
    end

    assign qualified = req && (run_q == QTOP);
endmodule

// File: rtl/linksync_lock_timer.sv
module linksync_lock_timer #(
    parameter int unsigned LOCK_WAIT = 2048
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int unsigned LW = linksync_pkg::cnt_width(LOCK_WAIT);
    localparam logic [LW-1:0] LTOP = LW'(LOCK_WAIT - 1);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (en && (cnt_q != LTOP))
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LTOP);
endmodule

// File: rtl/linksync_burst_counter.sv
module linksync_burst_counter #(
    parameter int unsigned BURST_LEN = 1024
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    input  logic run,
    output logic last
);
    localparam int unsigned BW = linksync_pkg::cnt_width(BURST_LEN);
    localparam logic [BW-1:0] BTOP = BW'(BURST_LEN - 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr || start)
            cnt_q <= '0;
        else if (run && (cnt_q != BTOP))
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == BTOP);
endmodule

// File: rtl/linksync_ctrl.sv
module linksync_ctrl
    import linksync_pkg::*;
#(
    parameter int unsigned LOCK_WAIT = 2048,
    parameter int unsigned QUAL_LEN  = 6,
    parameter int unsigned BURST_LEN = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down_n,
    input  logic req_a,
    input  logic req_b,
    output logic send_sync,
    output logic locked,
    output logic data_valid
);
    link_mode_e mode_q, mode_d;
    logic       clr, req_any, qualified, lock_done, burst_last, burst_start;
    logic       dv_q;

    assign clr     = rst || !pwr_down_n;
    assign req_any = req_a || req_b;

    linksync_qualify #(.QUAL_LEN(QUAL_LEN)) u_qual (
        .clk(clk), .clr(clr), .req(req_any), .qualified(qualified)
    );

    linksync_lock_timer #(.LOCK_WAIT(LOCK_WAIT)) u_lock (
        .clk(clk), .clr(clr), .en(mode_q == MODE_INIT), .done(lock_done)
    );

    linksync_burst_counter #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .clr(clr), .start(burst_start),
        .run(mode_q == MODE_SYNC), .last(burst_last)
    );

    always_comb begin
        mode_d      = mode_q;
        burst_start = 1'b0;
        unique case (mode_q)
            MODE_INIT: begin
                if (lock_done) begin
                    if (qualified) begin
                        mode_d      = MODE_SYNC;
                        burst_start = 1'b1;
                    end else begin
                        mode_d = MODE_DATA;
                    end
                end
            end
            MODE_DATA: begin
                if (qualified) begin
                    mode_d      = MODE_SYNC;
                    burst_start = 1'b1;
                end
            end
            MODE_SYNC: begin
                if (burst_last && !req_any)
                    mode_d = MODE_DATA;
            end
            default: mode_d = MODE_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            mode_q <= MODE_INIT;
            dv_q   <= 1'b0;
        end else begin
            mode_q <= mode_d;
            dv_q   <= (mode_d == MODE_DATA) && !req_any;
        end
    end

    assign send_sync  = (mode_q == MODE_SYNC);
    assign locked     = (mode_q != MODE_INIT);
    assign data_valid = dv_q;
endmodule

// File: rtl/linksync_checker.sv
module linksync_checker #(
    parameter int unsigned QUAL_LEN  = 6,
    parameter int unsigned BURST_LEN = 1024
) (
    input logic clk,
    input logic rst,
    input logic pwr_down_n,
    input logic req_a,
    input logic req_b,
    input logic send_sync,
    input logic locked,
    input logic data_valid
);
    localparam int unsigned SW = $clog2(BURST_LEN + 1) + 1;
    localparam int unsigned HW = $clog2(QUAL_LEN + 1) + 1;

    logic          clr;
    logic [SW-1:0] sync_run;
    logic [HW-1:0] hi_run;

    assign clr = rst || !pwr_down_n;

    always_ff @(posedge clk) begin
        if (clr || !send_sync)
            sync_run <= '0;
        else if (sync_run != SW'(BURST_LEN))
            sync_run <= sync_run + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr || !(req_a || req_b))
            hi_run <= '0;
        else if (hi_run != HW'(QUAL_LEN))
            hi_run <= hi_run + 1'b1;
    end

    assert_reset_quiet_R6: assert property (@(posedge clk)
        rst |=> !locked && !send_sync && !data_valid);

    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !pwr_down_n |=> !locked && !send_sync && !data_valid);

    assert_one_mode_R10: assert property (@(posedge clk) disable iff (rst)
        !(send_sync && data_valid));

    assert_data_locked_R8: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> locked);

    assert_data_req_low_R8: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> !$past(req_a || req_b));

    assert_qualified_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(send_sync) |-> (hi_run >= HW'(QUAL_LEN)));

    assert_burst_min_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(send_sync) && locked) |-> (sync_run >= SW'(BURST_LEN)));

    assert_burst_extend_R4: assert property (@(posedge clk) disable iff (rst)
        (send_sync && (req_a || req_b) && pwr_down_n) |=> send_sync);
endmodule

bind linksync_ctrl linksync_checker #(
    .QUAL_LEN(QUAL_LEN), .BURST_LEN(BURST_LEN)
) u_linksync_chk (
    .clk(clk), .rst(rst), .pwr_down_n(pwr_down_n), .req_a(req_a),
    .req_b(req_b), .send_sync(send_sync), .locked(locked),
    .data_valid(data_valid)
);

// File: tb/linksync_ctrl_test.sv
module linksync_ctrl_test;
    localparam int NPULSE = 7;
    // pulse high length, request source (bit0 = req_a, bit1 = req_b), expected sync words
    localparam int          PULSE_HI  [NPULSE] = '{1, 3, 5, 6, 7, 40, 1500};
    localparam logic [1:0]  PULSE_SEL [NPULSE] = '{2'b01, 2'b10, 2'b11, 2'b01, 2'b10, 2'b11, 2'b01};
    localparam int          PULSE_EXP [NPULSE] = '{0, 0, 0, 1024, 1024, 1024, 1495};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_down_n = 1'b1;
    logic req_a = 1'b0;
    logic req_b = 1'b0;
    logic send_sync, locked, data_valid;

    int n_chk = 0;
    int n_fail = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    linksync_ctrl uut (
        .clk(clk), .rst(rst), .pwr_down_n(pwr_down_n), .req_a(req_a),
        .req_b(req_b), .send_sync(send_sync), .locked(locked),
        .data_valid(data_valid)
    );

    always @(negedge clk) if (send_sync && data_valid) overlap++;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // call right after the negedge that drops rst or raises pwr_down_n
    task automatic expect_lock(input string rq);
        repeat (2047) @(negedge clk);
        chk(!locked && !send_sync && !data_valid, rq, {locked, send_sync, data_valid}, 0);
        @(negedge clk);
        chk(locked, rq, locked, 1);
    endtask

    // drive a request pattern for hi edges, then count sync words until data returns
    task automatic pulse(input int hi, input logic [1:0] sel, output int nsync, output int bad_dv,
                         output bit dv_back);
        nsync = 0; bad_dv = 0; dv_back = 1'b0;
        for (int k = 0; k <= hi; k++) begin
            @(negedge clk);
            if (k > 0) begin
                if (send_sync) nsync++;
                else if (data_valid) bad_dv++;
            end
            {req_b, req_a} = (k < hi) ? sel : 2'b00;
        end
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (send_sync) nsync++;
            else begin
                dv_back = data_valid;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int ns, bd;
        bit back;
        // R6: reset state
        repeat (3) @(negedge clk);
        chk(!locked && !send_sync && !data_valid, "R6 reset", {locked, send_sync, data_valid}, 0);
        rst = 1'b0;
        expect_lock("R6 lock wait");
        chk(data_valid, "R8 data after lock", data_valid, 1);

        // R1 R2 R3 R4 R5 R8: table of request pulses from data mode
        for (int i = 0; i < NPULSE; i++) begin
            pulse(PULSE_HI[i], PULSE_SEL[i], ns, bd, back);
            chk(ns == PULSE_EXP[i], "R1/R2/R3/R4/R5 sync words", ns, PULSE_EXP[i]);
            chk(bd == 0, "R8 no data while request high", bd, 0);
            chk(back, "R4 data resumes", back, 1);
        end

        // R2: a low edge restarts qualification
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            req_a = (k != 3) && (k < 7);
        end
        ns = 0;
        repeat (4) begin
            @(negedge clk);
            if (send_sync) ns++;
        end
        chk(ns == 0 && data_valid, "R2 gap clears count", ns, 0);

        // R3: toggling during the burst does not change its length
        ns = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k > 0 && send_sync) ns++;
            req_b = (k < 6) || ((k < 30) && k[0]);
        end
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (send_sync) ns++; else break;
        end
        chk(ns == 1024, "R3 toggled burst length", ns, 1024);
        chk(data_valid, "R3 data after toggled burst", data_valid, 1);

        // R7: power-down in the middle of a burst
        req_a = 1'b1;
        repeat (20) @(negedge clk);
        req_a = 1'b0;
        chk(send_sync, "R5 burst running", send_sync, 1);
        pwr_down_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!locked && !send_sync && !data_valid, "R7 power-down quiet",
            {locked, send_sync, data_valid}, 0);
        pwr_down_n = 1'b1;
        expect_lock("R7 relock");
        chk(data_valid && !send_sync, "R7 data after relock", data_valid, 1);

        // R9: request qualified during the lock wait
        @(negedge clk);
        rst = 1'b1;
        req_b = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_lock("R9 lock with request");
        chk(send_sync && !data_valid, "R9 straight into sync", send_sync, 1);
        req_b = 1'b0;
        ns = 1;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (send_sync) ns++; else break;
        end
        chk(ns == 1024, "R9 burst after lock", ns, 1024);
        chk(data_valid, "R9 data after burst", data_valid, 1);

        // R10: never sync and data in one word
        chk(overlap == 0, "R10 exclusive modes", overlap, 0);
        report();
    end
endmodule